// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Search Engine

This block searches for the best receive sampling delay tap on a high-speed card interface. On a start request, if the selected speed mode calls for tuning, it steps through every candidate tap in ascending order. For each tap it places the tap value in the tuning field of a control word and raises a tune-update request. The PHY must acknowledge the request. This update handshake is done twice per tap, which works around a receive-path timing fault in the PHY. The block then asks an external checker for one tuning-block transfer and waits for a pass or fail verdict.

While it sweeps, the engine tracks the longest run of consecutive passing taps. When the last candidate has been scored, it programs the tap at the middle of that run, again with a double update, and pulses done. If no tap passed, it raises an error flag and pulses done. For modes that need no tuning, a start request completes at once and leaves the tap alone.

Top module: `tap_tune_engine`

## Requirements
- R1: After reset, `ctrl_word_o` is all zero, and `xfer_req_o`, `done_o` and `err_o` are low.
- R2: Candidate taps are tried in ascending order 0, 1, ..., 39. The tap field never holds a value above 39.
- R3: `ctrl_word_o` places the tap in bits 13:8 and the update request in bit 15. Bits 2:0 hold the mode of the most recent accepted start. Bit 14 and bits 7:3 are zero.
- R4: Every tap programming holds the update request high until `upd_ack_i` is seen. The request then goes low for at least one cycle and rises a second time for the same tap. A transfer for that tap is requested only after the second acknowledge.
- R5: If an update request goes unacknowledged for `UPD_TIMEOUT` cycles, it is dropped. The tap counts as failed, no second update is made and no transfer is requested for it.
- R6: A failing tap resets the current run to zero. Only a strictly longer run replaces the best run, so of two equally long runs the earlier one wins.
- R7: After tap 39 has been scored, the engine programs the tap equal to (last tap of best run) minus (best run length / 2), rounded down. It uses a double update, then pulses done.
- R8: If no tap passed, `err_o` rises together with a done pulse and the tap field keeps the value 39. `err_o` stays high until the next accepted start.
- R9: Tuning runs only when `mode_i` = 4 (eMMC HS200), or when `mode_i` = 0 (SD) and `sd_fast_i` = 1. The other mode codes are 2 (eMMC SDR), 3 (eMMC DDR), 5 (HS400) and 6 (HS400 enhanced strobe). For any mode that does not tune, `done_o` pulses in the cycle after start, with no update, no transfer and no change to the tap.
- R10: Each accepted start produces exactly one `done_o` pulse, and that pulse is one cycle long.
- R11: A start request that arrives while a search is in progress is ignored.
- R12: `xfer_req_o` is a one-cycle pulse issued once per tested tap. It is never high in the same cycle as the update request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a tuning search (one-cycle pulse) |
| mode_i | input | 3 | Speed mode code, sampled on start |
| sd_fast_i | input | 1 | SD card in its fastest single-data-rate timing |
| upd_ack_i | input | 1 | PHY has applied the pending tune update |
| res_valid_i | input | 1 | Transfer verdict strobe from the checker |
| res_pass_i | input | 1 | Verdict: 1 = tuning block received correctly |
| ctrl_word_o | output | 16 | Control word: update request, tap field, mode field |
| xfer_req_o | output | 1 | Request one tuning-block transfer |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No passing tap found in the last search |

## Verification
Two things can fall in the same cycle: a passing verdict on the last candidate, tap 39, that also extends the best run, and the choice of the final tap. A correct engine must build the centre from a best run that already includes tap 39. This case is provoked by a passing window that ends at the top of the range. It is judged by comparing the programmed final tap with the centre the bench model computes. A second overlap puts an update timeout inside a passing window, where a failed score must break the run in the same decision step that moves to the next tap. It is checked through the full logged sequence of update and transfer taps.

// File: rtl/tune_pkg.sv
package tune_pkg;

  typedef enum logic [2:0] {
    MODE_SD       = 3'd0,
    MODE_MMC_SDR  = 3'd2,
    MODE_MMC_DDR  = 3'd3,
    MODE_HS200    = 3'd4,
    MODE_HS400    = 3'd5,
    MODE_HS400_ES = 3'd6
  } speed_mode_e;

  typedef enum logic [1:0] {
    U_IDLE,
    U_REQ,
    U_GAP
  } upd_state_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_XFER,
    S_WAIT,
    S_DECIDE,
    S_FINAL
  } seq_state_e;

  // Search is needed only for HS200 or the fast SD timing.
  function automatic logic is_tunable(input logic [2:0] mode, input logic sd_fast);
    return (mode == 3'(MODE_HS200)) || ((mode == 3'(MODE_SD)) && sd_fast);
  endfunction

  // Middle of the best window: its last tap minus half its length.
  function automatic int centre_tap(input int last_tap, input int run_len);
    return last_tap - (run_len / 2);
  endfunction

endpackage

// File: rtl/tune_upd_ctrl.sv
module tune_upd_ctrl
  import tune_pkg::*;
#(
  parameter int UPD_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic ack_i,
  output logic req_o,
  output logic ok_o,
  output logic tmo_o
);

  localparam int CW = $clog2(UPD_TIMEOUT + 1);

  upd_state_e      st_q;
  logic            second_q;
  logic [CW-1:0]   cnt_q;
  logic            ok_q;
  logic            tmo_q;

  // Named internal events for the checks below.
  logic ack_seen;
  logic wait_expired;
  assign ack_seen     = (st_q == U_REQ) && ack_i;
  assign wait_expired = (st_q == U_REQ) && !ack_i && (cnt_q == CW'(UPD_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= U_IDLE;
      second_q <= 1'b0;
      cnt_q    <= '0;
      ok_q     <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      ok_q  <= 1'b0;
      tmo_q <= 1'b0;
      unique case (st_q)
        U_IDLE: begin
          if (go_i) begin
            st_q     <= U_REQ;
            second_q <= 1'b0;
            cnt_q    <= '0;
          end
        end
        U_REQ: begin
          if (ack_seen) begin
            if (!second_q) begin
              st_q     <= U_GAP;
              second_q <= 1'b1;
            end else begin
              st_q <= U_IDLE;
              ok_q <= 1'b1;
            end
          end else if (wait_expired) begin
            st_q  <= U_IDLE;
            tmo_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        U_GAP: begin
          st_q  <= U_REQ;
          cnt_q <= '0;
        end
        default: st_q <= U_IDLE;
      endcase
    end
  end

  assign req_o = (st_q == U_REQ);
  assign ok_o  = ok_q;
  assign tmo_o = tmo_q;

  // R4
  req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |=> !req_o);

  // R5
  tmo_needs_unanswered_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> ($past(req_o) && !$past(ack_i)));

  // R4
  ok_tmo_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && tmo_o));

endmodule

// File: rtl/tune_window_trk.sv
module tune_window_trk #(
  parameter int TAP_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             score_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [LEN_W-1:0] best_len_o,
  output logic [TAP_W-1:0] best_end_o
);

  logic [LEN_W-1:0] cur_q;
  logic [LEN_W-1:0] best_len_q;
  logic [TAP_W-1:0] best_end_q;

  logic [LEN_W-1:0] run_next;
  logic             new_best;
  logic             run_break;
  assign run_next  = cur_q + 1'b1;
  assign new_best  = score_i && pass_i && (run_next > best_len_q);
  assign run_break = score_i && !pass_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cur_q      <= '0;
      best_len_q <= '0;
      best_end_q <= '0;
    end else if (score_i) begin
      if (pass_i) begin
        cur_q <= run_next;
        if (new_best) begin
          best_len_q <= run_next;
          best_end_q <= tap_i;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  assign best_len_o = best_len_q;
  assign best_end_o = best_end_q;

  // R6
  best_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (best_len_o >= $past(best_len_o)));

  // R6
  fail_keeps_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_break && !clear_i) |=> $stable(best_len_o) && $stable(best_end_o));

endmodule

// File: rtl/tune_seq_fsm.sv
module tune_seq_fsm
  import tune_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int TAP_LAST = 39,
  parameter int LEN_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  input  logic             sd_fast_i,
  input  logic             res_valid_i,
  input  logic             res_pass_i,
  input  logic             upd_ok_i,
  input  logic             upd_tmo_i,
  input  logic [LEN_W-1:0] best_len_i,
  input  logic [TAP_W-1:0] best_end_i,
  output logic             upd_go_o,
  output logic             trk_clear_o,
  output logic             score_o,
  output logic             pass_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [2:0]       mode_o,
  output logic             xfer_req_o,
  output logic             done_o,
  output logic             err_o
);

  seq_state_e       st_q;
  logic [TAP_W-1:0] tap_q;
  logic [2:0]       mode_q;
  logic             go_q;
  logic             done_q;
  logic             err_q;

  logic accept_tune;
  logic at_last;
  assign accept_tune = (st_q == S_IDLE) && start_i && is_tunable(mode_i, sd_fast_i);
  assign at_last     = (tap_q == TAP_W'(TAP_LAST));

  assign trk_clear_o = accept_tune;
  assign score_o     = ((st_q == S_WAIT) && res_valid_i) || ((st_q == S_PROG) && upd_tmo_i);
  assign pass_o      = (st_q == S_WAIT) && res_pass_i;
  assign xfer_req_o  = (st_q == S_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tap_q  <= '0;
      mode_q <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (start_i) begin
            mode_q <= mode_i;
            err_q  <= 1'b0;
            if (accept_tune) begin
              tap_q <= '0;
              go_q  <= 1'b1;
              st_q  <= S_PROG;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        S_PROG: begin
          if (upd_ok_i)       st_q <= S_XFER;
          else if (upd_tmo_i) st_q <= S_DECIDE;
        end
        S_XFER: st_q <= S_WAIT;
        S_WAIT: begin
          if (res_valid_i) st_q <= S_DECIDE;
        end
        S_DECIDE: begin
          if (at_last) begin
            if (best_len_i == '0) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end else begin
              tap_q <= TAP_W'(centre_tap(int'(best_end_i), int'(best_len_i)));
              go_q  <= 1'b1;
              st_q  <= S_FINAL;
            end
          end else begin
            tap_q <= tap_q + 1'b1;
            go_q  <= 1'b1;
            st_q  <= S_PROG;
          end
        end
        S_FINAL: begin
          if (upd_ok_i || upd_tmo_i) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign upd_go_o = go_q;
  assign tap_o    = tap_q;
  assign mode_o   = mode_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  // R2
  tap_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_q <= TAP_W'(TAP_LAST));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  err_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (best_len_i == '0));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != S_IDLE) && start_i) |=> $stable(mode_o));

endmodule

// File: rtl/tap_tune_engine.sv
module tap_tune_engine #(
  parameter int TAP_W       = 6,
  parameter int TAP_LAST    = 39,
  parameter int UPD_TIMEOUT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [2:0]  mode_i,
  input  logic        sd_fast_i,
  input  logic        upd_ack_i,
  input  logic        res_valid_i,
  input  logic        res_pass_i,
  output logic [15:0] ctrl_word_o,
  output logic        xfer_req_o,
  output logic        done_o,
  output logic        err_o
);

  localparam int LEN_W     = $clog2(TAP_LAST + 2);
  localparam int TAP_LSB   = 8;
  localparam int UPD_BIT   = 15;

  logic             upd_go, upd_req, upd_ok, upd_tmo;
  logic             trk_clear, score, pass;
  logic [LEN_W-1:0] best_len;
  logic [TAP_W-1:0] best_end;
  logic [TAP_W-1:0] tap;
  logic [2:0]       mode_q;

  tune_seq_fsm #(
    .TAP_W    (TAP_W),
    .TAP_LAST (TAP_LAST),
    .LEN_W    (LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .sd_fast_i   (sd_fast_i),
    .res_valid_i (res_valid_i),
    .res_pass_i  (res_pass_i),
    .upd_ok_i    (upd_ok),
    .upd_tmo_i   (upd_tmo),
    .best_len_i  (best_len),
    .best_end_i  (best_end),
    .upd_go_o    (upd_go),
    .trk_clear_o (trk_clear),
    .score_o     (score),
    .pass_o      (pass),
    .tap_o       (tap),
    .mode_o      (mode_q),
    .xfer_req_o  (xfer_req_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  tune_upd_ctrl #(
    .UPD_TIMEOUT (UPD_TIMEOUT)
  ) u_upd (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (upd_go),
    .ack_i (upd_ack_i),
    .req_o (upd_req),
    .ok_o  (upd_ok),
    .tmo_o (upd_tmo)
  );

  tune_window_trk #(
    .TAP_W (TAP_W),
    .LEN_W (LEN_W)
  ) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (trk_clear),
    .score_i    (score),
    .pass_i     (pass),
    .tap_i      (tap),
    .best_len_o (best_len),
    .best_end_o (best_end)
  );

  always_comb begin
    ctrl_word_o                        = '0;
    ctrl_word_o[UPD_BIT]               = upd_req;
    ctrl_word_o[TAP_LSB +: TAP_W]      = tap;
    ctrl_word_o[2:0]                   = mode_q;
  end

  // R12
  xfer_not_with_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> !upd_req);

  // R12
  xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |=> !xfer_req_o);

endmodule

// File: tb/tap_tune_engine_tb_top.sv
module tap_tune_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        sd_fast_i = 1'b0;
  logic        upd_ack_i = 1'b0;
  logic        res_valid_i = 1'b0;
  logic        res_pass_i = 1'b0;
  logic [15:0] ctrl_word_o;
  logic        xfer_req_o, done_o, err_o;

  always #10 clk = ~clk;  // 50 MHz

  tap_tune_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .sd_fast_i(sd_fast_i), .upd_ack_i(upd_ack_i), .res_valid_i(res_valid_i),
    .res_pass_i(res_pass_i), .ctrl_word_o(ctrl_word_o), .xfer_req_o(xfer_req_o),
    .done_o(done_o), .err_o(err_o)
  );

  wire [5:0] tap = ctrl_word_o[13:8];
  wire       req = ctrl_word_o[15];

  int n_chk = 0, n_fail = 0;
  bit [39:0] pat, stk;
  int upd_q[$], xfer_q[$], exp_upd[$], exp_xfer[$];
  int done_cnt, done_tap, done_err, exp_tap, exp_err, last_tap;
  bit [15:0] done_word;
  bit prev_req, prev_done, collecting;
  int phy_cnt, chk_cnt, wd_cnt;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // PHY model: acknowledges an update after two cycles unless the tap is stuck.
  always @(negedge clk) begin
    if (!rst_n) begin phy_cnt = 0; upd_ack_i = 1'b0; end
    else if (req && !stk[tap]) begin
      phy_cnt++;
      upd_ack_i = (phy_cnt == 2);
    end else begin
      phy_cnt = 0;
      upd_ack_i = 1'b0;
    end
  end

  // Transfer checker model: verdict three cycles after the request.
  always @(negedge clk) begin
    res_valid_i = 1'b0;
    if (chk_cnt > 0) begin
      chk_cnt--;
      if (chk_cnt == 0) begin res_valid_i = 1'b1; res_pass_i = pat[tap]; end
    end
    if (rst_n && xfer_req_o) chk_cnt = 3;
  end

  // Per-cycle observation and event logging.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(tap <= 6'd39, "R2 tap range", tap, 39);
      chk(!(xfer_req_o && req), "R12 xfer with update", int'(xfer_req_o && req), 0);
      chk(!(done_o && prev_done), "R10 done width", int'(done_o && prev_done), 0);
      if (collecting) begin
        if (req && !prev_req) upd_q.push_back(tap);
        if (xfer_req_o) xfer_q.push_back(tap);
        if (done_o) begin
          done_cnt++;
          if (done_cnt == 1) begin done_tap = tap; done_err = err_o; done_word = ctrl_word_o; end
        end
      end
      prev_req = req;
      prev_done = done_o;
    end
  end

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd_cnt, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic bit [39:0] win(input int lo, input int hi);
    bit [39:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Behavioural expectation from the requirements.
  task automatic model(input bit tun);
    int cur = 0, best = 0, bend = 0;
    exp_upd.delete(); exp_xfer.delete();
    if (!tun) begin exp_tap = last_tap; exp_err = 0; return; end
    for (int t = 0; t < 40; t++) begin
      if (stk[t]) begin exp_upd.push_back(t); cur = 0; end
      else begin
        exp_upd.push_back(t); exp_upd.push_back(t); exp_xfer.push_back(t);
        if (pat[t]) begin cur++; if (cur > best) begin best = cur; bend = t; end end
        else cur = 0;
      end
    end
    if (best == 0) begin exp_err = 1; exp_tap = 39; end
    else begin
      exp_err = 0; exp_tap = bend - best / 2;
      exp_upd.push_back(exp_tap); exp_upd.push_back(exp_tap);
    end
  endtask

  task automatic run_case(input logic [2:0] m, input bit f, input bit busy, input string rq);
    bit tun = (m == 3'd4) || (m == 3'd0 && f);
    model(tun);
    upd_q.delete(); xfer_q.delete(); done_cnt = 0;
    @(negedge clk); collecting = 1'b1;
    @(negedge clk); mode_i = m; sd_fast_i = f; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (!tun) chk(done_o == 1'b1, "R9 immediate done", int'(done_o), 1);
    for (int i = 0; i < 3000 && done_cnt == 0; i++) begin
      @(negedge clk);
      if (busy && i == 60) begin start_i = 1'b1; mode_i = 3'd3; end
      if (busy && i == 61) start_i = 1'b0;
    end
    repeat (4) @(negedge clk);
    collecting = 1'b0;
    chk(done_cnt == 1, "R10 one done per start", done_cnt, 1);
    chk(upd_q.size() == exp_upd.size(), tun ? "R4 update count" : "R9 no update", upd_q.size(), exp_upd.size());
    for (int k = 0; k < upd_q.size() && k < exp_upd.size(); k++)
      chk(upd_q[k] == exp_upd[k], stk != 0 ? "R5 update tap" : "R4 update tap", upd_q[k], exp_upd[k]);
    chk(xfer_q.size() == exp_xfer.size(), tun ? "R12 transfer count" : "R9 no transfer", xfer_q.size(), exp_xfer.size());
    for (int k = 0; k < xfer_q.size() && k < exp_xfer.size(); k++)
      chk(xfer_q[k] == exp_xfer[k], "R2 tested tap order", xfer_q[k], exp_xfer[k]);
    chk(done_tap == exp_tap, rq, done_tap, exp_tap);
    chk(done_err == exp_err, "R8 error flag", done_err, exp_err);
    chk(done_word[2:0] == m, "R3 mode field", done_word[2:0], m);
    chk(done_word[14] == 1'b0 && done_word[7:3] == 5'd0, "R3 spare bits", done_word[7:0], m);
    last_tap = exp_tap;
  endtask

  initial begin
    stk = '0; pat = '0; last_tap = 0; collecting = 1'b0;
    repeat (3) @(negedge clk);
    chk(ctrl_word_o == 16'd0, "R1 ctrl after reset", ctrl_word_o, 0);
    chk(!xfer_req_o && !done_o && !err_o, "R1 flags after reset", {xfer_req_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_word_o == 16'd0, "R1 ctrl idle", ctrl_word_o, 0);

    pat = win(10, 19);                       run_case(3'd4, 1'b0, 1'b0, "R7 centre of window");
    pat = win(3, 7) | win(20, 24);           run_case(3'd4, 1'b0, 1'b0, "R6 tie keeps earlier");
    pat = win(30, 39);                       run_case(3'd0, 1'b1, 1'b0, "R7 window at top, SD fast R9");
    pat = '0;                                run_case(3'd4, 1'b0, 1'b0, "R8 tap on error");
    repeat (5) @(negedge clk);
    chk(err_o == 1'b1, "R8 error held", err_o, 1);
    run_case(3'd3, 1'b0, 1'b0, "R9 tap unchanged (DDR)");
    chk(err_o == 1'b0, "R8 error cleared by start", err_o, 0);
    run_case(3'd0, 1'b0, 1'b0, "R9 tap unchanged (SD slow)");
    run_case(3'd6, 1'b1, 1'b0, "R9 tap unchanged (HS400 ES)");
    pat = win(8, 17); stk = 40'd1 << 12;     run_case(3'd4, 1'b0, 1'b0, "R5 timeout splits window");
    stk = '0;
    pat = 40'd1;                             run_case(3'd4, 1'b0, 1'b0, "R6 single tap window");
    pat = win(0, 39);                        run_case(3'd4, 1'b0, 1'b0, "R7 all pass");
    pat = win(5, 14);                        run_case(3'd4, 1'b0, 1'b1, "R11 start while busy");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule